// File: doc/BRIEF.md
# Packet buffer page allocator

This block manages a packet memory cut into 256-byte pages. A host issues commands that take memory, give it back, and queue packets for transmission. An allocate command carries the wanted page count minus one. The block finds the lowest run of free pages that is contiguous and long enough, then binds the run to the lowest unused packet number. That number appears in the result register, and a completion flag is raised in the interrupt word. The host can mask that flag and clear it by writing a 1. A request that is too large fails at once. A request that cannot yet be met waits and completes on its own once enough pages come back.

Packets are handed to a transmit queue by number. The transmitter signals when it has finished the packet at the head of the queue. When the auto-release control is on and the transmission succeeded, the pages of that packet return to the pool with no host action. A reset command empties the whole pool. A busy flag covers the two cycles after each accepted command, and commands seen while it is high are dropped.

Top module: `pkt_page_alloc`

## Requirements
- R1: After reset, result is 8'h80, int_word is 0, irq and busy are 0, free_cnt is 16 and txq_valid is 0.
- R2: Allocate (cmd_op 1) with cmd_arg 0..7 asks for cmd_arg+1 pages. The block takes the lowest-based free contiguous run and the lowest unused packet number P. After the accepting edge, result is {1'b0,3'b000,P}, int_word bit 0 is 1, and free_cnt has dropped by the page count.
- R3: Allocate with cmd_arg 8..15 fails. Result becomes 8'h80 and int_word bit 0 is set, and no page is taken.
- R4: An allocate that cannot be met becomes pending. It leaves the flag, result and free_cnt unchanged, and it completes as in R2 one cycle after enough pages are freed. Further allocates while one is pending are ignored.
- R5: In int_word, bit 0 is the allocation-done flag and bit 8 is its enable. A write with int_wdata[0]=1 clears the flag, and every write loads the enable from int_wdata[8]. irq is flag AND enable. A completion in the same cycle as a clear leaves the flag set.
- R6: busy is high for exactly 2 cycles after an accepted command (cmd_op 1..4), and commands presented while busy is high have no effect.
- R7: Release (cmd_op 3) of packet number cmd_arg returns its pages to the pool. A release of an unused number changes nothing.
- R8: Enqueue (cmd_op 4) of a used packet number appends it to the transmit queue. txq_head shows the oldest entry and txq_valid that the queue is not empty. A tx_done pulse removes the head entry. An enqueue of an unused number does nothing.
- R9: On tx_done with tx_ok=1 and auto_rel=1, the head packet's pages are freed. With either tx_ok or auto_rel at 0, they stay allocated.
- R10: Reset command (cmd_op 2) frees all 16 pages, empties the queue and drops any pending allocate.
- R11: A host release and an automatic release of different packets in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | 1 allocate, 2 reset pool, 3 release, 4 enqueue |
| cmd_arg | input | 4 | Page count minus one, or packet number |
| int_wr | input | 1 | Write strobe for the interrupt word |
| int_wdata | input | 16 | Bit 0 write-1-to-clear flag, bit 8 enable |
| auto_rel | input | 1 | Free successfully sent packets automatically |
| tx_done | input | 1 | Head packet finished transmitting |
| tx_ok | input | 1 | That transmission succeeded |
| result | output | 8 | Bit 7 failure, low bits packet number |
| int_word | output | 16 | Enable in bit 8, flag in bit 0 |
| irq | output | 1 | Interrupt request |
| busy | output | 1 | Command engine busy |
| free_cnt | output | 5 | Number of free pages |
| txq_head | output | 4 | Packet number at the queue head |
| txq_valid | output | 1 | Queue not empty |

## Verification
Two paths can return pages in one cycle: a host release command, and the automatic release that follows a successful transmission. The bench presents a release command for one packet on the same edge as a successful tx_done for another packet at the queue head. It then expects free_cnt to rise by both page counts. A second overlap pairs a flag-clear write with an allocation completing on the same edge, and the flag must remain set.

// File: rtl/pkt_page_alloc.sv
module pkt_page_alloc #(
  parameter int PAGES    = 16,
  parameter int PKTS     = 16,
  parameter int MAXREQ   = 7,
  parameter int BUSY_CYC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [2:0]  cmd_op,
  input  logic [3:0]  cmd_arg,
  input  logic        int_wr,
  input  logic [15:0] int_wdata,
  input  logic        auto_rel,
  input  logic        tx_done,
  input  logic        tx_ok,
  output logic [7:0]  result,
  output logic [15:0] int_word,
  output logic        irq,
  output logic        busy,
  output logic [$clog2(PAGES):0] free_cnt,
  output logic [$clog2(PKTS)-1:0] txq_head,
  output logic        txq_valid
);
  localparam int PW = $clog2(PAGES);
  localparam int NW = $clog2(PKTS);
  localparam int BW = $clog2(BUSY_CYC + 1);

  logic [PAGES-1:0] free_map;
  logic [PKTS-1:0]  used;
  logic [PW-1:0]    base_r [PKTS];
  logic [PW:0]      len_r  [PKTS];
  logic             pend;
  logic [PW:0]      pend_len;
  logic [NW-1:0]    q [PKTS];
  logic [NW-1:0]    rd, wr;
  logic [NW:0]      qcnt;
  logic [BW-1:0]    busy_cnt;
  logic             flag, mask;

  function automatic logic [PAGES-1:0] span(input logic [PW:0] n, input logic [PW-1:0] b);
    logic [PAGES-1:0] m;
    for (int i = 0; i < PAGES; i++)
      m[i] = (i >= int'(b)) && (i < int'(b) + int'(n));
    return m;
  endfunction

  wire accept    = cmd_valid && busy_cnt == '0 && cmd_op >= 3'd1 && cmd_op <= 3'd4;
  wire do_reset  = accept && cmd_op == 3'd2;
  wire do_alloc  = accept && cmd_op == 3'd1 && !pend;
  wire bad_req   = do_alloc && int'(cmd_arg) > MAXREQ;
  wire [NW-1:0] arg_p = cmd_arg[NW-1:0];
  wire want      = pend || (do_alloc && !bad_req);
  wire [PW:0] want_len = pend ? pend_len : (PW+1)'(cmd_arg) + 1'b1;

  logic [PAGES-1:0] fit;
  for (genvar b = 0; b < PAGES; b++) begin : g_fit
    assign fit[b] = (b + int'(want_len) <= PAGES) &&
                    ((span(want_len, PW'(b)) & ~free_map) == '0);
  end

  logic [PW-1:0] gbase;
  logic [NW-1:0] gnum;
  logic          gnum_ok;
  always_comb begin
    gbase = '0;
    for (int i = PAGES-1; i >= 0; i--) if (fit[i]) gbase = PW'(i);
    gnum = '0;
    gnum_ok = 1'b0;
    for (int i = PKTS-1; i >= 0; i--) if (!used[i]) begin gnum = NW'(i); gnum_ok = 1'b1; end
  end

  wire grant  = want && |fit && gnum_ok && !do_reset;
  wire pop    = tx_done && qcnt != '0;
  wire [NW-1:0] hd = q[rd];
  wire rel_h  = accept && cmd_op == 3'd3 && used[arg_p];
  wire rel_a  = pop && auto_rel && tx_ok && used[hd];
  wire push   = accept && cmd_op == 3'd4 && used[arg_p] && (int'(qcnt) < PKTS || pop);

  wire [PAGES-1:0] freed = (rel_h ? span(len_r[arg_p], base_r[arg_p]) : '0) |
                           (rel_a ? span(len_r[hd], base_r[hd]) : '0);
  wire [PAGES-1:0] taken = grant ? span(want_len, gbase) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_map <= '1;
      used     <= '0;
      pend     <= 1'b0;
      pend_len <= '0;
      rd       <= '0;
      wr       <= '0;
      qcnt     <= '0;
      result   <= 8'h80;
      for (int i = 0; i < PKTS; i++) begin
        base_r[i] <= '0;
        len_r[i]  <= '0;
        q[i]      <= '0;
      end
    end else if (do_reset) begin
      free_map <= '1;
      used     <= '0;
      pend     <= 1'b0;
      rd       <= '0;
      wr       <= '0;
      qcnt     <= '0;
    end else begin
      free_map <= (free_map | freed) & ~taken;
      for (int i = 0; i < PKTS; i++) begin
        if ((rel_h && arg_p == NW'(i)) || (rel_a && hd == NW'(i))) used[i] <= 1'b0;
        if (grant && gnum == NW'(i)) begin
          used[i]   <= 1'b1;
          base_r[i] <= gbase;
          len_r[i]  <= want_len;
        end
      end
      if (grant) begin
        pend   <= 1'b0;
        result <= {1'b0, (7-NW)'(0), gnum};
      end else if (do_alloc && !bad_req) begin
        pend     <= 1'b1;
        pend_len <= want_len;
      end
      if (bad_req) result <= 8'h80;
      if (push) begin
        q[wr] <= arg_p;
        wr    <= wr + 1'b1;
      end
      if (pop) rd <= rd + 1'b1;
      qcnt <= qcnt + (NW+1)'(push) - (NW+1)'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
      flag     <= 1'b0;
      mask     <= 1'b0;
    end else begin
      if (accept) busy_cnt <= BW'(BUSY_CYC);
      else if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
      if (grant || bad_req) flag <= 1'b1;
      else if (int_wr && int_wdata[0]) flag <= 1'b0;
      if (int_wr) mask <= int_wdata[8];
    end
  end

  always_comb begin
    free_cnt = '0;
    for (int i = 0; i < PAGES; i++) free_cnt = free_cnt + (PW+1)'(free_map[i]);
  end

  assign busy      = busy_cnt != '0;
  assign int_word  = {7'b0, mask, 7'b0, flag};
  assign irq       = flag & mask;
  assign txq_head  = hd;
  assign txq_valid = qcnt != '0;
endmodule

module pkt_page_alloc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [2:0]  cmd_op,
  input logic [3:0]  cmd_arg,
  input logic        int_wr,
  input logic [15:0] int_wdata,
  input logic        tx_done,
  input logic        busy,
  input logic        grant,
  input logic [7:0]  result,
  input logic [15:0] int_word,
  input logic [4:0]  free_cnt,
  input logic        txq_valid
);
  p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy);
  p_busy_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |=> !busy);
  p_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tx_done) |=> $stable(txq_valid));
  p_bad_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op == 3'd1 && cmd_arg > 4'd7 && !grant) |=> (result == 8'h80 && int_word[0]));
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (int_wr && int_wdata[0] && !grant && !(cmd_valid && !busy && cmd_op == 3'd1)) |=> !int_word[0]);
  p_pool_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op == 3'd2) |=> (free_cnt == 5'd16 && !txq_valid));
endmodule

bind pkt_page_alloc pkt_page_alloc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
  .int_wr(int_wr), .int_wdata(int_wdata), .tx_done(tx_done), .busy(busy), .grant(grant),
  .result(result), .int_word(int_word), .free_cnt(free_cnt), .txq_valid(txq_valid)
);

// File: tb/pkt_page_alloc_bench.sv
module pkt_page_alloc_bench;
  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, int_wr = 0, auto_rel = 0, tx_done = 0, tx_ok = 0;
  logic [2:0] cmd_op = 0;
  logic [3:0] cmd_arg = 0;
  logic [15:0] int_wdata = 0;
  logic [7:0] result;
  logic [15:0] int_word;
  logic irq, busy, txq_valid;
  logic [4:0] free_cnt;
  logic [3:0] txq_head;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pkt_page_alloc u_pkt_page_alloc (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
    .int_wr(int_wr), .int_wdata(int_wdata), .auto_rel(auto_rel), .tx_done(tx_done),
    .tx_ok(tx_ok), .result(result), .int_word(int_word), .irq(irq), .busy(busy),
    .free_cnt(free_cnt), .txq_head(txq_head), .txq_valid(txq_valid)
  );

  task automatic chk(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic cmd(int op, int arg);
    @(negedge clk);
    cmd_valid = 1; cmd_op = 3'(op); cmd_arg = 4'(arg);
    @(negedge clk);
    cmd_valid = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic iwrite(int d);
    @(negedge clk);
    int_wr = 1; int_wdata = 16'(d);
    @(negedge clk);
    int_wr = 0;
  endtask

  task automatic txpulse(bit ok);
    @(negedge clk);
    tx_done = 1; tx_ok = ok;
    @(negedge clk);
    tx_done = 0; tx_ok = 0;
  endtask

  task automatic t_reset;
    chk("R1 result", result, 8'h80);
    chk("R1 int_word", int_word, 0);
    chk("R1 irq", irq, 0);
    chk("R1 busy", busy, 0);
    chk("R1 free", free_cnt, 16);
    chk("R1 txq", txq_valid, 0);
  endtask

  task automatic t_alloc;
    cmd(1, 0);
    chk("R2 result p0", result, 8'h00);
    chk("R2 flag", int_word[0], 1);
    chk("R2 free", free_cnt, 15);
    iwrite(16'h0001);
    chk("R5 clear", int_word[0], 0);
    cmd(1, 2);
    chk("R2 result p1", result, 8'h01);
    chk("R2 free 3 pages", free_cnt, 12);
    cmd(1, 9);
    chk("R3 fail result", result, 8'h80);
    chk("R3 flag", int_word[0], 1);
    chk("R3 no pages", free_cnt, 12);
    iwrite(16'h0100);
    chk("R5 irq on", irq, 1);
    chk("R5 word", int_word, 16'h0101);
    iwrite(16'h0101);
    chk("R5 irq off", irq, 0);
    chk("R5 word enable", int_word, 16'h0100);
  endtask

  task automatic t_busy;
    @(negedge clk);
    cmd_valid = 1; cmd_op = 1; cmd_arg = 0;
    @(negedge clk);
    chk("R6 busy 1", busy, 1);
    @(negedge clk);
    chk("R6 busy 2", busy, 1);
    @(negedge clk);
    chk("R6 busy end", busy, 0);
    cmd_valid = 0;
    chk("R6 ignored alloc", free_cnt, 11);
    chk("R6 result p2", result, 8'h02);
    @(negedge clk);
  endtask

  task automatic t_release;
    cmd(3, 0);
    chk("R7 release p0", free_cnt, 12);
    cmd(3, 9);
    chk("R7 unused number", free_cnt, 12);
    cmd(3, 0);
    chk("R7 double release", free_cnt, 12);
  endtask

  task automatic t_setwin;
    @(negedge clk);
    cmd_valid = 1; cmd_op = 1; cmd_arg = 0;
    int_wr = 1; int_wdata = 16'h0001;
    @(negedge clk);
    cmd_valid = 0; int_wr = 0;
    chk("R5 set wins", int_word[0], 1);
    chk("R2 reuse p0", result, 8'h00);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_resetcmd;
    cmd(4, 0);
    chk("R8 queued", txq_valid, 1);
    chk("R8 head", txq_head, 0);
    cmd(2, 0);
    chk("R10 free all", free_cnt, 16);
    chk("R10 queue empty", txq_valid, 0);
  endtask

  task automatic t_pending;
    cmd(1, 7);
    cmd(1, 7);
    chk("R2 full", free_cnt, 0);
    chk("R2 p1 base 8", result, 8'h01);
    iwrite(16'h0001);
    cmd(1, 1);
    chk("R4 pending flag", int_word[0], 0);
    chk("R4 pending result", result, 8'h01);
    cmd(1, 0);
    chk("R4 second ignored", free_cnt, 0);
    cmd(3, 0);
    chk("R4 completed", result, 8'h00);
    chk("R4 flag", int_word[0], 1);
    chk("R4 free", free_cnt, 6);
    cmd(3, 1);
    chk("R4 no second grant", free_cnt, 14);
  endtask

  task automatic t_queue;
    cmd(2, 0);
    cmd(1, 0);
    cmd(1, 1);
    chk("R2 free 13", free_cnt, 13);
    cmd(4, 0);
    cmd(4, 1);
    chk("R8 head p0", txq_head, 0);
    auto_rel = 1;
    txpulse(1);
    chk("R9 auto free", free_cnt, 14);
    chk("R8 head p1", txq_head, 1);
    auto_rel = 0;
    txpulse(1);
    chk("R9 no auto", free_cnt, 14);
    chk("R8 drained", txq_valid, 0);
    cmd(4, 5);
    chk("R8 unused enqueue", txq_valid, 0);
    cmd(4, 1);
    auto_rel = 1;
    txpulse(0);
    chk("R9 failed tx kept", free_cnt, 14);
    chk("R8 popped", txq_valid, 0);
    auto_rel = 0;
  endtask

  task automatic t_collide;
    cmd(2, 0);
    cmd(1, 0);
    cmd(1, 0);
    cmd(1, 0);
    chk("R11 setup", free_cnt, 13);
    cmd(4, 0);
    auto_rel = 1;
    @(negedge clk);
    cmd_valid = 1; cmd_op = 3; cmd_arg = 1;
    tx_done = 1; tx_ok = 1;
    @(negedge clk);
    cmd_valid = 0; tx_done = 0; tx_ok = 0;
    chk("R11 both freed", free_cnt, 15);
    chk("R11 queue popped", txq_valid, 0);
    auto_rel = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_alloc;
    t_busy;
    t_release;
    t_setwin;
    t_resetcmd;
    t_pending;
    t_queue;
    t_collide;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule